// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block drives the four status lights of a 10/100 Ethernet transceiver: traffic activity, link up, 100 Mbit/s speed and full duplex. It takes the carrier-sense signal, two link-valid flags (one per speed), the resolved speed, an auto-negotiation-busy flag, the line-isolate control bit and the duplex mode. From these it produces one light level per pin.

Activity lights while carrier sense is high. It stays lit for a programmable hold time after carrier sense drops. The hold is counted in milliseconds through a prescaler derived from the clock frequency. Each LED pin also serves as an address strap on the board. The value read from a pin while reset is held chooses that pin's polarity. While reset is low the pins show the inactive level, so the straps can be read.

Top module: `phy_led_ctrl`

## Requirements
- R1: The activity light (pin index 0) is lit, one clock after any edge at which `crs` is sampled high.
- R2: After `crs` is sampled low, activity stays lit for STRETCH_MS × (CLK_HZ/1000) further clock edges and then goes dark. A new high on `crs` during the hold restarts the full hold.
- R3: The link light (pin index 1) follows `link100_ok` when `spd100` is 1, and follows `link10_ok` when `spd100` is 0.
- R4: The speed light (pin index 2) is lit when `spd100` or `aneg_busy` is 1, and is dark when both are 0.
- R5: When `isolate` is 1, the speed light is dark, whatever `spd100` and `aneg_busy` are.
- R6: The duplex light (pin index 3) is lit exactly when `full_dup` is 1.
- R7: A captured strap value of 1 makes that pin active low (lit = 0). A strap value of 0 makes it active high (lit = 1).
- R8: While `rst_n` is low, each `led_out` bit equals the matching `strap_in` bit, which is that pin's inactive level.
- R9: The strap value seen at the last clock edge with `rst_n` low is held until the next reset. Changes on `strap_in` after release have no effect on the outputs.
- R10: Every light level is registered. An input change shows on `led_out` after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| crs | input | 1 | Carrier sense |
| link10_ok | input | 1 | 10 Mbit/s link test passed |
| link100_ok | input | 1 | 100 Mbit/s link test passed |
| spd100 | input | 1 | Resolved speed is 100 Mbit/s |
| aneg_busy | input | 1 | Auto-negotiation in progress |
| isolate | input | 1 | Line isolation control bit |
| full_dup | input | 1 | Link runs in full duplex |
| strap_in | input | 4 | Value read back from the LED pins (strap) |
| led_out | output | 4 | Pin drive: [0] activity, [1] link, [2] speed, [3] duplex |

## Verification
The bench builds the block with CLK_HZ = 4000 and STRETCH_MS = 3. That gives four clocks per millisecond and a hold of twelve clocks. The end of the hold, the restart during a hold, and a hold left to run fully are therefore all reached within a few dozen cycles. Two resets with opposite strap patterns put every pin through both polarities. The strap input is moved after each release to show that it is ignored.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

  localparam int unsigned NUM_LEDS = 4;
  localparam int unsigned LED_ACT  = 0;
  localparam int unsigned LED_LNK  = 1;
  localparam int unsigned LED_SPD  = 2;
  localparam int unsigned LED_DUP  = 3;

  // clocks in one millisecond, never below one
  function automatic int unsigned ticks_per_ms(input int unsigned hz);
    return (hz / 1000 == 0) ? 1 : hz / 1000;
  endfunction

  // link-test status chosen by the resolved speed
  function automatic logic link_level(input logic fast, input logic ok10,
                                      input logic ok100);
    return fast ? ok100 : ok10;
  endfunction

  // isolation wins over speed and negotiation
  function automatic logic speed_level(input logic fast, input logic neg,
                                       input logic iso);
    return !iso && (fast || neg);
  endfunction

  // strap 1 means active low
  function automatic logic pin_drive(input logic lit, input logic strap);
    return lit ^ strap;
  endfunction

endpackage

// File: rtl/act_stretch.sv
module act_stretch #(
  parameter int unsigned CLK_HZ     = 25_000_000,
  parameter int unsigned STRETCH_MS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crs,
  output logic act_lvl,
  output logic hold
);
  import phy_led_pkg::*;

  localparam int unsigned TPM   = ticks_per_ms(CLK_HZ);
  localparam int unsigned PRE_W = $clog2(TPM + 1);
  localparam int unsigned MS_W  = $clog2(STRETCH_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TPM - 1);
  localparam logic [MS_W-1:0]  MS_LOAD  = MS_W'(STRETCH_MS);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             ms_tick;

  assign ms_tick = (pre_q == PRE_LAST);
  assign hold    = (ms_q != '0);
  assign act_lvl = crs || hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (crs) begin
      pre_q <= '0;
      ms_q  <= MS_LOAD;
    end else if (hold) begin
      if (ms_tick) begin
        pre_q <= '0;
        ms_q  <= ms_q - MS_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crs |=> (ms_q == MS_LOAD && pre_q == '0));

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_q == '0 && !crs) |=> (ms_q == '0));

  // R1
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crs |=> hold);

endmodule

// File: rtl/led_pins.sv
module led_pins #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strap_in,
  input  logic [N-1:0] lvl_next,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] strap_q,
  output logic [N-1:0] led_out
);
  import phy_led_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_pin
    // strap sampled on every edge while reset is held, frozen after release
    always_ff @(posedge clk) begin
      if (!rst_n) strap_q[i] <= strap_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl_next[i];
    end

    assign led_out[i] = rst_n ? pin_drive(lvl_q[i], strap_q[i]) : strap_in[i];
  end

  // R9
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strap_q));

  // R10
  lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_q == $past(lvl_next)));

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl #(
  parameter int unsigned CLK_HZ     = 25_000_000,
  parameter int unsigned STRETCH_MS = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crs,
  input  logic       link10_ok,
  input  logic       link100_ok,
  input  logic       spd100,
  input  logic       aneg_busy,
  input  logic       isolate,
  input  logic       full_dup,
  input  logic [3:0] strap_in,
  output logic [3:0] led_out
);
  import phy_led_pkg::*;

  logic                act_lvl;
  logic                act_hold;
  logic [NUM_LEDS-1:0] lvl_next;
  logic [NUM_LEDS-1:0] lvl_now;
  logic [NUM_LEDS-1:0] strap_now;

  act_stretch #(
    .CLK_HZ    (CLK_HZ),
    .STRETCH_MS(STRETCH_MS)
  ) i_stretch (
    .clk    (clk),
    .rst_n  (rst_n),
    .crs    (crs),
    .act_lvl(act_lvl),
    .hold   (act_hold)
  );

  always_comb begin
    lvl_next          = '0;
    lvl_next[LED_ACT] = act_lvl;
    lvl_next[LED_LNK] = link_level(spd100, link10_ok, link100_ok);
    lvl_next[LED_SPD] = speed_level(spd100, aneg_busy, isolate);
    lvl_next[LED_DUP] = full_dup;
  end

  led_pins #(.N(NUM_LEDS)) i_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_in(strap_in),
    .lvl_next(lvl_next),
    .lvl_q   (lvl_now),
    .strap_q (strap_now),
    .led_out (led_out)
  );

  // R5
  iso_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isolate |=> !lvl_now[LED_SPD]);

  // R4
  spd_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!isolate && (spd100 || aneg_busy)) |=> lvl_now[LED_SPD]);

  // R3
  link_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spd100 && !link100_ok) |=> !lvl_now[LED_LNK]);

  // R6
  dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_now[LED_DUP] == $past(full_dup)));

  // R1
  act_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crs |=> lvl_now[LED_ACT]);

endmodule

// File: tb/test_phy_led_ctrl.sv
module test_phy_led_ctrl;

  localparam int unsigned CLK_HZ      = 4000;
  localparam int unsigned STRETCH_MS  = 3;
  localparam int          STRETCH_CYC = STRETCH_MS * (CLK_HZ / 1000);

  logic       clk = 1'b0;
  logic       rst_n;
  logic       crs, link10_ok, link100_ok, spd100, aneg_busy, isolate, full_dup;
  logic [3:0] strap_in;
  logic [3:0] led_out;

  int n_chk = 0;
  int n_bad = 0;
  string phase = "init";

  // reference state
  int         rem = 0;
  logic [3:0] exp_lvl = '0;
  logic [3:0] strap_m = '0;

  always #5 clk = ~clk;

  phy_led_ctrl #(.CLK_HZ(CLK_HZ), .STRETCH_MS(STRETCH_MS)) i_phy_led_ctrl (
    .clk(clk), .rst_n(rst_n), .crs(crs), .link10_ok(link10_ok),
    .link100_ok(link100_ok), .spd100(spd100), .aneg_busy(aneg_busy),
    .isolate(isolate), .full_dup(full_dup), .strap_in(strap_in),
    .led_out(led_out)
  );

  // behavioural model, updated at each rising edge (R10: one edge of latency)
  always @(posedge clk) begin
    if (!rst_n) begin
      strap_m = strap_in;
      rem     = 0;
      exp_lvl = '0;
    end else begin
      exp_lvl[0] = crs || (rem > 0);
      if (crs) rem = STRETCH_CYC;
      else if (rem > 0) rem = rem - 1;
      exp_lvl[1] = spd100 ? link100_ok : link10_ok;
      exp_lvl[2] = isolate ? 1'b0 : (spd100 || aneg_busy);
      exp_lvl[3] = full_dup;
    end
  end

  function automatic string tag(input int i);
    case (i)
      0: return "R1/R2";
      1: return "R3";
      2: return "R4/R5";
      default: return "R6";
    endcase
  endfunction

  // R7: pin = lit XOR strap; R8: in reset pin = strap_in
  task automatic check_pins();
    for (int i = 0; i < 4; i++) begin
      logic want;
      want = rst_n ? (exp_lvl[i] ^ strap_m[i]) : strap_in[i];
      n_chk++;
      if (led_out[i] !== want) begin
        n_bad++;
        $display("FAIL %s pin %0d [%s] got %b expected %b",
                 rst_n ? tag(i) : "R8", i, phase, led_out[i], want);
      end
    end
  endtask

  task automatic run(input logic c, input logic l10, input logic l100,
                     input logic s, input logic a, input logic iso,
                     input logic fd, input int n);
    crs = c; link10_ok = l10; link100_ok = l100; spd100 = s;
    aneg_busy = a; isolate = iso; full_dup = fd;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_pins();
    end
  endtask

  task automatic sweep();
    phase = "R3 link select";
    for (int v = 0; v < 8; v++) run(1'b0, v[0], v[1], v[2], 1'b0, 1'b0, 1'b0, 2);
    phase = "R4 R5 speed and isolate";
    for (int v = 0; v < 8; v++) run(1'b0, 1'b0, 1'b0, v[0], v[1], v[2], v[0], 2);
    phase = "R6 duplex";
    run(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3);
    run(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3);
  endtask

  initial begin
    rst_n = 1'b0;
    strap_in = 4'b1010;
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    phase = "R8 reset level";
    run(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2);
    strap_in = 4'b0110;
    run(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1);
    strap_in = 4'b1010;
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    rst_n = 1'b1;
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    phase = "R9 strap ignored after release";
    strap_in = 4'b0101;
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    phase = "R1 R2 full hold";
    run(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4);
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, STRETCH_CYC + 4);
    phase = "R2 restart during hold";
    run(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, STRETCH_CYC - 3);
    run(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, STRETCH_CYC + 3);
    sweep();

    phase = "R8 second reset";
    rst_n = 1'b0;
    strap_in = 4'b0101;
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3);
    rst_n = 1'b1;
    run(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    phase = "R7 R9 opposite polarity";
    strap_in = 4'b1111;
    run(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3);
    run(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, STRETCH_CYC + 2);
    sweep();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired [%s]", phase);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule